// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames from a byte stream into system memory. Each incoming frame carries markers for its first byte, its last byte, a bad frame-check-sequence indication and a broadcast indication. The block stores the bytes into fixed-size buffers. Each buffer is described by a two-word descriptor in a circular ring held in the same memory. A single word-wide memory port with a fixed one-cycle read latency is used for descriptor fetches, data stores and status write-back.

Software prepares the ring. Word 0 of each descriptor holds a buffer address, an ownership bit and a wrap bit. Software hands a buffer to the block by clearing its ownership bit. The block hands the buffer back by setting that bit once a whole frame is stored. A frame longer than one buffer runs on into the following descriptors. Software rebuilds it by adding up the per-buffer byte counts from the start-marked buffer to the end-marked one. Writing the ring base pointer moves the walk back to the first descriptor and clears a halted condition.

Top module: `rxring_dma`

## Requirements
- R1: After reset no memory access is made, `rx_done` and `bna_flag` are low, `rx_ready` is high while no start byte is offered, and the first frame uses the descriptor at the address given by parameter `BASE_RST`.
- R2: A fetched descriptor whose word-0 bit 0 (ownership) is 1 is not written. `bna_flag` goes high and stays high. The rest of that frame is consumed. All later input is accepted and discarded with no memory access until the base pointer is written.
- R3: Word-0 bits [31:2] give the buffer address. Byte k of a buffer is stored in the word at buffer address + 4*(k/4), bits [8*(k%4)+7 : 8*(k%4)]. Lanes past the last byte of a frame in its final word are written as zero.
- R4: The buffer size is `cfg_buf_units` × `UNIT_BYTES` bytes. A frame that fills a buffer continues in the next descriptor. A frame whose last byte exactly fills a buffer uses no further descriptor.
- R5: Descriptor word 1 (status) holds the buffer's byte count in bits [12:0]. Bit 14 is set on the frame's first buffer and bit 15 on its last buffer. Bit 13 carries the bad-check flag on the last buffer only. Bit 31 carries the broadcast flag on every buffer of the frame. All other bits are zero.
- R6: After a descriptor whose word-0 bit 1 (wrap) is set, the next descriptor is the one at the base pointer. Otherwise the next descriptor is 8 bytes further on.
- R7: Ownership bits of all descriptors used by a frame are set, in ring order and with the other word-0 bits kept, only after the frame's end-marked status word has been written. A single one-cycle `rx_done` pulse then follows.
- R8: A base-pointer write (`base_wr`) sets the walk to that address (low three bits cleared), clears `bna_flag` and ends any halt.
- R9: Bytes offered without a start marker while no frame is in progress are accepted and discarded with no memory access.
- R10: A start byte is held (`rx_ready` low) until a free descriptor has been fetched for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_buf_units | input | UNITS_W | Buffer size in units of UNIT_BYTES (nonzero) |
| base_wr | input | 1 | Base-pointer write strobe |
| base_addr | input | AW | New ring base address |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Stream byte accepted this cycle when valid |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | Byte is first of a frame |
| rx_eof | input | 1 | Byte is last of a frame |
| rx_fcs_bad | input | 1 | Frame check failed, valid with the last byte |
| rx_bcast | input | 1 | Broadcast destination, valid with the first byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |
| rx_done | output | 1 | One-cycle pulse when a frame is handed to software |
| bna_flag | output | 1 | Sticky buffer-not-available flag |

## Verification
The bench builds the block with `UNIT_BYTES` = 16 and `BASE_RST` = 0x100, over a four-descriptor ring. It switches `cfg_buf_units` between 2 and 1 at run time, so 32-byte and 16-byte buffers are both covered. Small buffers let short frames span three descriptors, end exactly on a buffer boundary and cross the wrap descriptor within a few dozen cycles. The non-zero reset base lets the first frame show that the walk starts without any base write. The small ring also makes an owned descriptor, and the halt that follows, quick to reach.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

   localparam int DESC_BYTES = 8;
   localparam int STAT_OFS   = 4;
   localparam int LEN_W      = 13;

   localparam int B_OWN   = 0;
   localparam int B_WRAP  = 1;
   localparam int B_FCS   = 13;
   localparam int B_SOF   = 14;
   localparam int B_EOF   = 15;
   localparam int B_BCAST = 31;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH,
      ST_FWAIT,
      ST_FILL,
      ST_STAT,
      ST_OWN_RD,
      ST_OWN_WR,
      ST_DROP,
      ST_HALT
   } rx_state_e;

   typedef struct packed {
      logic             bcast;
      logic             fcs;
      logic             sof;
      logic             eof;
      logic [LEN_W-1:0] len;
   } stat_fields_t;

   function automatic logic [31:0] pack_status(input stat_fields_t f);
      logic [31:0] w;
      w          = '0;
      w[LEN_W-1:0] = f.len;
      w[B_FCS]   = f.fcs;
      w[B_SOF]   = f.sof;
      w[B_EOF]   = f.eof;
      w[B_BCAST] = f.bcast;
      return w;
   endfunction

endpackage

// File: rtl/rxring_ptr.sv
module rxring_ptr
   import rxring_pkg::*;
#(
   parameter int          AW       = 32,
   parameter logic [AW-1:0] BASE_RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          base_wr,
   input  logic [AW-1:0] base_in,
   input  logic          cur_adv,
   input  logic          cur_wrap,
   input  logic          first_mark,
   input  logic          walk_load,
   input  logic          walk_adv,
   input  logic          walk_wrap,
   output logic [AW-1:0] cur_ptr,
   output logic [AW-1:0] walk_ptr
);

   localparam logic [AW-1:0] ALIGN = ~AW'(DESC_BYTES - 1);

   logic [AW-1:0] base_q;
   logic [AW-1:0] first_q;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                          input logic          w,
                                          input logic [AW-1:0] b);
      return w ? b : p + AW'(DESC_BYTES);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= BASE_RST & ALIGN;
         cur_ptr <= BASE_RST & ALIGN;
      end else if (base_wr) begin
         base_q <= base_in & ALIGN;
         cur_ptr <= base_in & ALIGN;
      end else if (cur_adv) begin
         cur_ptr <= step(cur_ptr, cur_wrap, base_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         walk_ptr <= '0;
      end else begin
         if (first_mark) first_q <= cur_ptr;
         if (walk_load) walk_ptr <= first_q;
         else if (walk_adv) walk_ptr <= step(walk_ptr, walk_wrap, base_q);
      end
   end

   // R8: a base write restarts the walk at the new (aligned) base
   p_base_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |=> (cur_ptr == ($past(base_in) & ALIGN)));

   // R6: wrap returns to base, otherwise step by one descriptor
   p_wrap_to_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_adv && cur_wrap && !base_wr) |=> (cur_ptr == base_q));
   p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_adv && !cur_wrap && !base_wr) |=> (cur_ptr == $past(cur_ptr) + AW'(DESC_BYTES)));

endmodule

// File: rtl/rxring_packer.sv
module rxring_packer (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        push,
   input  logic        flush,
   input  logic [1:0]  lane,
   input  logic [7:0]  din,
   output logic [31:0] word
);

   logic [31:0] acc;

   always_comb begin
      word = acc;
      word[{lane, 3'b000} +: 8] = din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else if (clr) acc <= '0;
      else if (push) acc <= flush ? '0 : word;
   end

endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
   import rxring_pkg::*;
#(
   parameter int AW         = 32,
   parameter int UNITS_W    = 8,
   parameter int UNIT_BYTES = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [UNITS_W-1:0] cfg_units,
   input  logic               base_wr,
   input  logic               rx_valid,
   output logic               rx_ready,
   input  logic               rx_sof,
   input  logic               rx_eof,
   input  logic               rx_fcs_bad,
   input  logic               rx_bcast,
   output logic               mem_req,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [31:0]        mem_wdata,
   input  logic [31:0]        mem_rdata,
   output logic               rx_done,
   output logic               bna,
   output logic               cur_adv,
   output logic               cur_wrap,
   output logic               first_mark,
   output logic               walk_load,
   output logic               walk_adv,
   output logic               walk_wrap,
   input  logic [AW-1:0]      cur_ptr,
   input  logic [AW-1:0]      walk_ptr,
   output logic               pk_clr,
   output logic               pk_push,
   output logic               pk_flush,
   output logic [1:0]         pk_lane,
   input  logic [31:0]        pk_word
);

   localparam int UB_W  = $clog2(UNIT_BYTES);
   localparam int CNT_W = UNITS_W + UB_W;

   rx_state_e        state;
   logic [CNT_W-1:0] cnt, cnt_nx, bufsize;
   logic [AW-1:0]    buf_addr;
   logic             wrap_q, first_buf, eof_q, fcs_q, bcast_q;
   logic             last_in_buf, walk_last;
   logic [LEN_W-1:0] len_f;
   stat_fields_t     sf;

   assign bufsize     = {cfg_units, {UB_W{1'b0}}};
   assign cnt_nx      = cnt + 1'b1;
   assign last_in_buf = (cnt_nx == bufsize);
   assign walk_last   = (walk_ptr == cur_ptr);

   generate
      if (CNT_W >= LEN_W) begin : g_len_trunc
         assign len_f = cnt[LEN_W-1:0];
      end else begin : g_len_ext
         assign len_f = {{(LEN_W-CNT_W){1'b0}}, cnt};
      end
   endgenerate

   always_comb begin
      sf.len   = len_f;
      sf.fcs   = fcs_q & eof_q;
      sf.sof   = first_buf;
      sf.eof   = eof_q;
      sf.bcast = bcast_q;
   end

   // packer control
   assign pk_clr   = (state == ST_FWAIT);
   assign pk_push  = (state == ST_FILL) && rx_valid;
   assign pk_flush = (cnt[1:0] == 2'd3) || rx_eof || last_in_buf;
   assign pk_lane  = cnt[1:0];

   // pointer control
   assign first_mark = (state == ST_IDLE) && rx_valid && rx_sof && !base_wr;
   assign cur_adv    = !base_wr && (((state == ST_STAT) && !eof_q) ||
                                    ((state == ST_OWN_WR) && walk_last));
   assign cur_wrap   = (state == ST_STAT) ? wrap_q : mem_rdata[B_WRAP];
   assign walk_load  = !base_wr && (state == ST_STAT) && eof_q;
   assign walk_adv   = !base_wr && (state == ST_OWN_WR) && !walk_last;
   assign walk_wrap  = mem_rdata[B_WRAP];

   always_comb begin
      unique case (state)
         ST_IDLE:                    rx_ready = !rx_sof;
         ST_FILL, ST_DROP, ST_HALT:  rx_ready = 1'b1;
         default:                    rx_ready = 1'b0;
      endcase
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_ptr;
      mem_wdata = pk_word;
      unique case (state)
         ST_FETCH: mem_req = 1'b1;
         ST_FILL: begin
            mem_req  = rx_valid && pk_flush;
            mem_we   = 1'b1;
            mem_addr = buf_addr + AW'({cnt[CNT_W-1:2], 2'b00});
         end
         ST_STAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_ptr + AW'(STAT_OFS);
            mem_wdata = pack_status(sf);
         end
         ST_OWN_RD: begin
            mem_req  = 1'b1;
            mem_addr = walk_ptr;
         end
         ST_OWN_WR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = walk_ptr;
            mem_wdata = mem_rdata | 32'h1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         buf_addr  <= '0;
         wrap_q    <= 1'b0;
         first_buf <= 1'b0;
         eof_q     <= 1'b0;
         fcs_q     <= 1'b0;
         bcast_q   <= 1'b0;
         bna       <= 1'b0;
         rx_done   <= 1'b0;
      end else begin
         rx_done <= 1'b0;
         if (base_wr) begin
            state <= ST_IDLE;
            bna   <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: if (rx_valid && rx_sof) begin
                  state     <= ST_FETCH;
                  bcast_q   <= rx_bcast;
                  first_buf <= 1'b1;
                  eof_q     <= 1'b0;
                  fcs_q     <= 1'b0;
               end
               ST_FETCH: state <= ST_FWAIT;
               ST_FWAIT: begin
                  if (mem_rdata[B_OWN]) begin
                     bna   <= 1'b1;
                     state <= ST_DROP;
                  end else begin
                     buf_addr <= mem_rdata & ~AW'(3);
                     wrap_q   <= mem_rdata[B_WRAP];
                     cnt      <= '0;
                     state    <= ST_FILL;
                  end
               end
               ST_FILL: if (rx_valid) begin
                  cnt <= cnt_nx;
                  if (rx_eof) begin
                     eof_q <= 1'b1;
                     fcs_q <= rx_fcs_bad;
                     state <= ST_STAT;
                  end else if (last_in_buf) begin
                     eof_q <= 1'b0;
                     state <= ST_STAT;
                  end
               end
               ST_STAT: begin
                  first_buf <= 1'b0;
                  state     <= eof_q ? ST_OWN_RD : ST_FETCH;
               end
               ST_OWN_RD: state <= ST_OWN_WR;
               ST_OWN_WR: begin
                  if (walk_last) begin
                     rx_done <= 1'b1;
                     state   <= ST_IDLE;
                  end else begin
                     state <= ST_OWN_RD;
                  end
               end
               ST_DROP: if (rx_valid && rx_eof) state <= ST_HALT;
               ST_HALT: ;
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R2: nothing reaches memory once the ring ran out of free buffers
   p_no_store_halted_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_DROP) || (state == ST_HALT)) |-> !mem_req);
   p_bna_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bna && !base_wr) |=> bna);

   // R4: data stores stay inside the current buffer
   p_store_in_buffer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_FILL) && mem_req) |-> ((mem_addr - buf_addr) < AW'(bufsize)));

   // R7: ownership hand-back only after an end-marked status, single pulse
   p_own_after_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && (state == ST_OWN_WR)) |-> (eof_q && mem_wdata[B_OWN]));
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R10: a start byte is held while its descriptor is fetched
   p_sof_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_FETCH) || (state == ST_FWAIT)) |-> !rx_ready);

endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
   import rxring_pkg::*;
#(
   parameter int            AW         = 32,
   parameter int            UNITS_W    = 8,
   parameter int            UNIT_BYTES = 64,
   parameter logic [AW-1:0] BASE_RST   = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [UNITS_W-1:0] cfg_buf_units,
   input  logic               base_wr,
   input  logic [AW-1:0]      base_addr,
   input  logic               rx_valid,
   output logic               rx_ready,
   input  logic [7:0]         rx_data,
   input  logic               rx_sof,
   input  logic               rx_eof,
   input  logic               rx_fcs_bad,
   input  logic               rx_bcast,
   output logic               mem_req,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [31:0]        mem_wdata,
   input  logic [31:0]        mem_rdata,
   output logic               rx_done,
   output logic               bna_flag
);

   generate
      if (UNIT_BYTES < 4 || (UNIT_BYTES & (UNIT_BYTES - 1)) != 0) begin : g_bad_unit
         $error("UNIT_BYTES must be a power of two of at least 4");
      end
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("AW must lie between 8 and 32");
      end
      if (UNITS_W < 1) begin : g_bad_units
         $error("UNITS_W must be at least 1");
      end
   endgenerate

   logic          cur_adv, cur_wrap, first_mark, walk_load, walk_adv, walk_wrap;
   logic [AW-1:0] cur_ptr, walk_ptr;
   logic          pk_clr, pk_push, pk_flush;
   logic [1:0]    pk_lane;
   logic [31:0]   pk_word;

   rxring_ptr #(.AW(AW), .BASE_RST(BASE_RST)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_wr    (base_wr),
      .base_in    (base_addr),
      .cur_adv    (cur_adv),
      .cur_wrap   (cur_wrap),
      .first_mark (first_mark),
      .walk_load  (walk_load),
      .walk_adv   (walk_adv),
      .walk_wrap  (walk_wrap),
      .cur_ptr    (cur_ptr),
      .walk_ptr   (walk_ptr)
   );

   rxring_packer u_pack (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pk_clr),
      .push  (pk_push),
      .flush (pk_flush),
      .lane  (pk_lane),
      .din   (rx_data),
      .word  (pk_word)
   );

   rxring_ctrl #(.AW(AW), .UNITS_W(UNITS_W), .UNIT_BYTES(UNIT_BYTES)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_units  (cfg_buf_units),
      .base_wr    (base_wr),
      .rx_valid   (rx_valid),
      .rx_ready   (rx_ready),
      .rx_sof     (rx_sof),
      .rx_eof     (rx_eof),
      .rx_fcs_bad (rx_fcs_bad),
      .rx_bcast   (rx_bcast),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .rx_done    (rx_done),
      .bna        (bna_flag),
      .cur_adv    (cur_adv),
      .cur_wrap   (cur_wrap),
      .first_mark (first_mark),
      .walk_load  (walk_load),
      .walk_adv   (walk_adv),
      .walk_wrap  (walk_wrap),
      .cur_ptr    (cur_ptr),
      .walk_ptr   (walk_ptr),
      .pk_clr     (pk_clr),
      .pk_push    (pk_push),
      .pk_flush   (pk_flush),
      .pk_lane    (pk_lane),
      .pk_word    (pk_word)
   );

endmodule

// File: tb/rxring_dma_tb.sv
module rxring_dma_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 32;
   localparam int UNITS_W    = 8;
   localparam int UNIT_BYTES = 16;
   localparam int RING_BASE  = 'h100;
   localparam int BUF_BASE   = 'h200;
   localparam logic [31:0] FILL = 32'hA5A5A5A5;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [UNITS_W-1:0] cfg_buf_units = 8'd2;
   logic               base_wr = 1'b0;
   logic [AW-1:0]      base_addr = '0;
   logic               rx_valid = 1'b0;
   logic               rx_ready;
   logic [7:0]         rx_data = '0;
   logic               rx_sof = 1'b0, rx_eof = 1'b0, rx_fcs_bad = 1'b0, rx_bcast = 1'b0;
   logic               mem_req, mem_we;
   logic [AW-1:0]      mem_addr;
   logic [31:0]        mem_wdata;
   logic [31:0]        mem_rdata = '0;
   logic               rx_done, bna_flag;

   logic [31:0] mem [256];
   int vectors = 0, miscompares = 0;
   int done_cnt = 0, req_cnt = 0, order_err = 0;
   bit eof_seen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxring_dma #(.AW(AW), .UNITS_W(UNITS_W), .UNIT_BYTES(UNIT_BYTES),
                .BASE_RST(32'(RING_BASE))) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_buf_units(cfg_buf_units),
      .base_wr(base_wr), .base_addr(base_addr),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_fcs_bad(rx_fcs_bad), .rx_bcast(rx_bcast),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rx_done(rx_done), .bna_flag(bna_flag));

   // memory model with one-cycle read latency, plus port monitors
   always @(posedge clk) begin
      if (mem_req) begin
         req_cnt++;
         if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
         else mem_rdata <= mem[mem_addr[9:2]];
         if (mem_we && mem_addr < 32'(BUF_BASE)) begin
            if (mem_addr[2] && mem_wdata[15]) eof_seen = 1;
            if (!mem_addr[2] && mem_wdata[0] && !eof_seen) order_err++;
         end
      end
      if (rx_done) eof_seen = 0;
   end

   always @(negedge clk) if (rx_done) done_cnt++;

   function automatic int desc_a(input int i); return RING_BASE + 8*i; endfunction
   function automatic int buf_a(input int i);  return BUF_BASE + 32*i; endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic release_desc(input int i);
      mem[desc_a(i) >> 2]     = 32'(buf_a(i)) | ((i == 3) ? 32'h2 : 32'h0);
      mem[(desc_a(i) >> 2) + 1] = '0;
      for (int w = 0; w < 8; w++) mem[(buf_a(i) >> 2) + w] = FILL;
   endtask

   task automatic send_frame(input int len, input logic [7:0] seed, input logic bc,
                             input logic fcs, output logic first_ready);
      first_ready = 1'b1;
      for (int i = 0; i < len; i++) begin
         logic got;
         bit   first;
         got = 1'b0;
         first = 1;
         while (!got) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(seed + i);
            rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_fcs_bad = fcs && (i == len - 1); rx_bcast = bc;
            #1;
            got = rx_ready;
            if (i == 0 && first) first_ready = rx_ready;
            first = 0;
            @(posedge clk);
         end
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_fcs_bad = 1'b0;
      repeat (30) @(negedge clk);
   endtask

   task automatic check_buf(input string req, input int addr, input logic [7:0] first_byte, input int n);
      for (int w = 0; w < (n + 3) / 4; w++) begin
         logic [31:0] e;
         e = '0;
         for (int l = 0; l < 4; l++)
            if (w*4 + l < n) e[l*8 +: 8] = 8'(first_byte + w*4 + l);
         chk(req, "buffer word", mem[(addr >> 2) + w], e);
      end
   endtask

   task automatic t_reset;
      @(negedge clk); #1;
      chk("R1", "mem_req", {31'b0, mem_req}, 32'h0);
      chk("R1", "rx_done", {31'b0, rx_done}, 32'h0);
      chk("R1", "bna_flag", {31'b0, bna_flag}, 32'h0);
      chk("R1", "rx_ready", {31'b0, rx_ready}, 32'h1);
   endtask

   task automatic t_short;
      int d0;
      logic fr;
      d0 = done_cnt;
      send_frame(6, 8'h10, 1'b1, 1'b0, fr);
      chk("R10", "ready on start byte", {31'b0, fr}, 32'h0);
      chk("R1", "first descriptor status", mem[(desc_a(0) >> 2) + 1], 32'h8000C006);
      chk("R7", "own bit desc0", mem[desc_a(0) >> 2], 32'h201);
      check_buf("R3", buf_a(0), 8'h10, 6);
      chk("R3", "untouched word after frame", mem[(buf_a(0) >> 2) + 2], FILL);
      chk("R7", "done pulses", 32'(done_cnt - d0), 32'h1);
   endtask

   task automatic t_multi;
      int d0;
      logic fr;
      d0 = done_cnt;
      send_frame(70, 8'h40, 1'b0, 1'b1, fr);
      chk("R5", "status first buffer", mem[(desc_a(1) >> 2) + 1], 32'h4020);
      chk("R5", "status middle buffer", mem[(desc_a(2) >> 2) + 1], 32'h0020);
      chk("R5", "status last buffer", mem[(desc_a(3) >> 2) + 1], 32'hA006);
      chk("R7", "own desc1", mem[desc_a(1) >> 2], 32'h221);
      chk("R7", "own desc2", mem[desc_a(2) >> 2], 32'h241);
      chk("R7", "own desc3 keeps wrap", mem[desc_a(3) >> 2], 32'h263);
      check_buf("R4", buf_a(1), 8'h40, 32);
      check_buf("R4", buf_a(2), 8'h60, 32);
      check_buf("R4", buf_a(3), 8'h80, 6);
      chk("R7", "single done for split frame", 32'(done_cnt - d0), 32'h1);
   endtask

   task automatic t_bna;
      int d0, r0;
      logic fr;
      d0 = done_cnt;
      send_frame(5, 8'h90, 1'b0, 1'b0, fr);
      chk("R2", "bna flag", {31'b0, bna_flag}, 32'h1);
      chk("R2", "owned status untouched", mem[(desc_a(0) >> 2) + 1], 32'h8000C006);
      chk("R2", "owned buffer untouched", mem[buf_a(0) >> 2], 32'h13121110);
      chk("R2", "no done", 32'(done_cnt - d0), 32'h0);
      r0 = req_cnt;
      send_frame(4, 8'hA0, 1'b0, 1'b0, fr);
      chk("R2", "halted: no memory access", 32'(req_cnt - r0), 32'h0);
      chk("R2", "bna stays", {31'b0, bna_flag}, 32'h1);
   endtask

   task automatic t_restart;
      logic fr;
      for (int i = 0; i < 4; i++) release_desc(i);
      cfg_buf_units = 8'd1;
      @(negedge clk);
      base_wr = 1'b1; base_addr = 32'(RING_BASE);
      @(negedge clk);
      base_wr = 1'b0;
      #1;
      chk("R8", "bna cleared", {31'b0, bna_flag}, 32'h0);
      send_frame(10, 8'h01, 1'b0, 1'b0, fr);
      chk("R8", "restart at first descriptor", mem[(desc_a(0) >> 2) + 1], 32'h0000C00A);
      check_buf("R3", buf_a(0), 8'h01, 10);
   endtask

   task automatic t_exact;
      logic fr;
      send_frame(16, 8'h30, 1'b0, 1'b0, fr);
      chk("R4", "exact fit status", mem[(desc_a(1) >> 2) + 1], 32'h0000C010);
      chk("R4", "next descriptor unused", mem[(desc_a(2) >> 2) + 1], 32'h0);
      check_buf("R4", buf_a(1), 8'h30, 16);
   endtask

   task automatic t_wrap;
      logic fr;
      release_desc(0);
      send_frame(40, 8'hC0, 1'b0, 1'b0, fr);
      chk("R6", "status desc2", mem[(desc_a(2) >> 2) + 1], 32'h4010);
      chk("R6", "status desc3", mem[(desc_a(3) >> 2) + 1], 32'h0010);
      chk("R6", "status after wrap", mem[(desc_a(0) >> 2) + 1], 32'h8008);
      chk("R6", "own after wrap", mem[desc_a(0) >> 2], 32'h201);
      check_buf("R6", buf_a(0), 8'hE0, 8);
   endtask

   task automatic t_stray;
      int r0;
      int notready;
      r0 = req_cnt;
      notready = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = 8'(i); rx_sof = 1'b0; rx_eof = (i == 4);
         #1;
         if (!rx_ready) notready++;
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_eof = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9", "stray bytes accepted", 32'(notready), 32'h0);
      chk("R9", "stray bytes: no memory access", 32'(req_cnt - r0), 32'h0);
      chk("R9", "desc1 unchanged", mem[(desc_a(1) >> 2) + 1], 32'h0000C010);
   endtask

   initial begin
      for (int a = 0; a < 256; a++) mem[a] = FILL;
      for (int i = 0; i < 4; i++) release_desc(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_short();
      t_multi();
      t_bna();
      t_restart();
      t_exact();
      t_stray();
      t_wrap();
      chk("R7", "ownership written only after end status", 32'(order_err), 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog R1-flow: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule